// File: doc/BRIEF.md
# Clock-Sweep Replacement Victim Selector

This block chooses which physical page frame to evict when a new page must be brought in. For every frame it holds two flags, a recently-used flag and a modified flag, plus a circular pointer into the frame set. The surrounding memory-management logic pulses a reference input whenever a frame is accessed and a write input whenever a frame is modified. When a replacement is needed it raises a request, and the block reports one frame index a few cycles later.

The search walks the frames one per clock, starting at the pointer. A frame whose recently-used flag is set gets a second chance: the flag is cleared and the walk moves on. The first frame found with the flag already clear is the victim. A second mode, picked per request, looks for a frame that is both not recently used and unmodified, so that no write-back is needed. If two full sweeps find no such frame, it settles for the first not-recently-used frame it saw. After each choice the pointer rests just past the victim. The victim's modified flag is cleared, because the frame is about to be refilled.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset every recently-used and modified flag is clear, the pointer is at frame 0, and `busy` and `victim_valid` are low. A first request in plain mode therefore returns frame 0 after one examination.
- R2: A pulse on `ref_valid` sets the recently-used flag of frame `ref_index`. A pulse on `wr_valid` sets the modified flag of frame `wr_index`. Both flags are visible from the next cycle.
- R3: In plain mode (`clean_mode` = 0) the block examines one frame per cycle from the pointer. It clears every set recently-used flag it passes and picks the first frame whose flag is clear. The modified flag is ignored. A victim found at the k-th examination raises `victim_valid` k+1 cycles after the request is sampled.
- R4: The walk advances modulo NUM_FRAMES. From frame NUM_FRAMES-1 it continues at frame 0, so a search with every flag set returns the starting frame after NUM_FRAMES+1 examinations.
- R5: `busy` is high from the cycle after a request is accepted until the victim is reported. `victim_valid` is a single-cycle pulse that carries `victim_index`. A request, and its mode, raised while `busy` is high is ignored.
- R6: After a victim is reported, the pointer sits on the frame after the victim, and the next search starts there.
- R7: In clean-preferred mode (`clean_mode` = 1) the victim is the first examined frame whose recently-used and modified flags are both clear. Set recently-used flags are still cleared as they are passed.
- R8: In clean-preferred mode, if 2*NUM_FRAMES examinations find no clean unused frame, the block reports the first frame it saw that was not recently used. Such a frame is always modified. The report comes at the 2*NUM_FRAMES-th examination.
- R9: A reference or write to the frame being examined in the same cycle takes priority over the scan. The flag ends up set, and the frame is judged with that flag set.
- R10: The modified flag of the reported victim is cleared in the cycle it is chosen, unless a write to that frame arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ref_valid | input | 1 | Frame access strobe |
| ref_index | input | IDX_W | Frame that was accessed |
| wr_valid | input | 1 | Frame modification strobe |
| wr_index | input | IDX_W | Frame that was modified |
| req_valid | input | 1 | Request for a replacement victim |
| clean_mode | input | 1 | 1 selects the clean-preferred search for this request |
| busy | output | 1 | Search in progress |
| victim_valid | output | 1 | One-cycle pulse: victim_index is valid |
| victim_index | output | IDX_W | Chosen frame |

## Verification
The bench targets the points where a sweep tends to go wrong. The first is wrap-around with every flag set: a pointer that does not wrap, or a scan that stops at the end of the array, returns the wrong frame or hangs. The second is the clean-preferred fallback: a bad sweep counter reports it early, late or never, and a bad fallback latch names the last dirty frame instead of the first. The third is same-cycle collisions: if clear wins over set, a frame touched while under the pointer is evicted at once, or loses its flag for the next sweep. It also checks that the pointer resumes past the victim, that a second request during a search cannot switch the mode, and that the victim's modified flag is dropped. A design that missed the last point would later fall back to that frame instead of taking it as clean.

// File: rtl/nru_pkg.sv
package nru_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_SCAN
    } scan_state_e;

    typedef struct packed {
        logic referenced;
        logic dirty;
    } frame_flags_t;

    typedef struct packed {
        logic pick_now;
        logic give_up;
        logic pick_fallback;
    } scan_verdict_t;

    function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/nru_flag_array.sv
module nru_flag_array
    import nru_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ref_set,
    input  logic [IDX_W-1:0]              ref_set_idx,
    input  logic                          dirty_set,
    input  logic [IDX_W-1:0]              dirty_set_idx,
    input  logic                          ref_clr,
    input  logic [IDX_W-1:0]              ref_clr_idx,
    input  logic                          dirty_clr,
    input  logic [IDX_W-1:0]              dirty_clr_idx,
    output frame_flags_t [NUM_FRAMES-1:0] flags
);

    // One flag pair per frame; a set request always wins over a clear.
    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

        always_ff @(posedge clk) begin
            if (rst) begin
                flags[g] <= '0;
            end else begin
                if (ref_set && ref_set_idx == MY_IDX) begin
                    flags[g].referenced <= 1'b1;
                end else if (ref_clr && ref_clr_idx == MY_IDX) begin
                    flags[g].referenced <= 1'b0;
                end

                if (dirty_set && dirty_set_idx == MY_IDX) begin
                    flags[g].dirty <= 1'b1;
                end else if (dirty_clr && dirty_clr_idx == MY_IDX) begin
                    flags[g].dirty <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/nru_scan_ctrl.sv
module nru_scan_ctrl
    import nru_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  frame_flags_t [NUM_FRAMES-1:0] flags,
    input  logic                          ref_valid,
    input  logic [IDX_W-1:0]              ref_index,
    input  logic                          wr_valid,
    input  logic [IDX_W-1:0]              wr_index,
    input  logic                          req_valid,
    input  logic                          clean_mode,
    output logic                          ref_clr,
    output logic [IDX_W-1:0]              ref_clr_idx,
    output logic                          dirty_clr,
    output logic [IDX_W-1:0]              dirty_clr_idx,
    output logic                          busy,
    output logic                          victim_valid,
    output logic [IDX_W-1:0]              victim_index
);

    localparam int SWEEP_EXAMS = 2 * NUM_FRAMES;
    localparam int CNT_W       = $clog2(SWEEP_EXAMS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SWEEP_EXAMS - 1);

    scan_state_e        state_q;
    logic [IDX_W-1:0]   ptr_q;
    logic               clean_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               fb_valid_q;
    logic [IDX_W-1:0]   fb_idx_q;
    logic               victim_valid_q;
    logic [IDX_W-1:0]   victim_index_q;

    logic               scanning;
    frame_flags_t       probe;
    scan_verdict_t      verdict;
    logic [IDX_W-1:0]   pick_idx;
    logic [IDX_W-1:0]   ptr_after_probe;
    logic [IDX_W-1:0]   ptr_after_pick;

    // Flags of the frame under the pointer, merged with same-cycle accesses.
    always_comb begin
        scanning         = (state_q == ST_SCAN);
        probe.referenced = flags[ptr_q].referenced | (ref_valid && ref_index == ptr_q);
        probe.dirty      = flags[ptr_q].dirty | (wr_valid && wr_index == ptr_q);

        verdict.pick_now      = scanning && !probe.referenced && (!clean_q || !probe.dirty);
        verdict.give_up       = scanning && clean_q && !verdict.pick_now && (cnt_q == CNT_LAST);
        verdict.pick_fallback = verdict.give_up && fb_valid_q;

        pick_idx        = verdict.pick_now ? ptr_q : fb_idx_q;
        ptr_after_probe = IDX_W'(ring_next(32'(ptr_q), NUM_FRAMES));
        ptr_after_pick  = IDX_W'(ring_next(32'(pick_idx), NUM_FRAMES));

        ref_clr       = scanning && !verdict.pick_now && flags[ptr_q].referenced;
        ref_clr_idx   = ptr_q;
        dirty_clr     = verdict.pick_now || verdict.pick_fallback;
        dirty_clr_idx = pick_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= ST_IDLE;
            ptr_q          <= '0;
            clean_q        <= 1'b0;
            cnt_q          <= '0;
            fb_valid_q     <= 1'b0;
            fb_idx_q       <= '0;
            victim_valid_q <= 1'b0;
            victim_index_q <= '0;
        end else begin
            victim_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q    <= ST_SCAN;
                        clean_q    <= clean_mode;
                        cnt_q      <= '0;
                        fb_valid_q <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (verdict.pick_now || verdict.pick_fallback) begin
                        victim_valid_q <= 1'b1;
                        victim_index_q <= pick_idx;
                        ptr_q          <= ptr_after_pick;
                        state_q        <= ST_IDLE;
                    end else begin
                        ptr_q <= ptr_after_probe;
                        cnt_q <= cnt_q + 1'b1;
                        if (clean_q && !probe.referenced && !fb_valid_q) begin
                            fb_valid_q <= 1'b1;
                            fb_idx_q   <= ptr_q;
                        end
                        if (verdict.give_up) begin
                            clean_q <= 1'b0;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy         = scanning;
    assign victim_valid = victim_valid_q;
    assign victim_index = victim_index_q;

endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel
    import nru_pkg::*;
#(
    parameter  int NUM_FRAMES = 8,
    localparam int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_index,
    input  logic             wr_valid,
    input  logic [IDX_W-1:0] wr_index,
    input  logic             req_valid,
    input  logic             clean_mode,
    output logic             busy,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_index
);

    frame_flags_t [NUM_FRAMES-1:0] flags;
    logic                          ref_clr;
    logic [IDX_W-1:0]              ref_clr_idx;
    logic                          dirty_clr;
    logic [IDX_W-1:0]              dirty_clr_idx;

    nru_flag_array #(
        .NUM_FRAMES(NUM_FRAMES),
        .IDX_W     (IDX_W)
    ) u_flags (
        .clk          (clk),
        .rst          (rst),
        .ref_set      (ref_valid),
        .ref_set_idx  (ref_index),
        .dirty_set    (wr_valid),
        .dirty_set_idx(wr_index),
        .ref_clr      (ref_clr),
        .ref_clr_idx  (ref_clr_idx),
        .dirty_clr    (dirty_clr),
        .dirty_clr_idx(dirty_clr_idx),
        .flags        (flags)
    );

    nru_scan_ctrl #(
        .NUM_FRAMES(NUM_FRAMES),
        .IDX_W     (IDX_W)
    ) u_scan (
        .clk          (clk),
        .rst          (rst),
        .flags        (flags),
        .ref_valid    (ref_valid),
        .ref_index    (ref_index),
        .wr_valid     (wr_valid),
        .wr_index     (wr_index),
        .req_valid    (req_valid),
        .clean_mode   (clean_mode),
        .ref_clr      (ref_clr),
        .ref_clr_idx  (ref_clr_idx),
        .dirty_clr    (dirty_clr),
        .dirty_clr_idx(dirty_clr_idx),
        .busy         (busy),
        .victim_valid (victim_valid),
        .victim_index (victim_index)
    );

endmodule

// File: rtl/nru_victim_sel_chk.sv
module nru_victim_sel_chk
    import nru_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = 3
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          ref_valid,
    input logic [IDX_W-1:0]              ref_index,
    input logic                          wr_valid,
    input logic [IDX_W-1:0]              wr_index,
    input logic                          req_valid,
    input logic                          busy,
    input logic                          victim_valid,
    input logic [IDX_W-1:0]              victim_index,
    input frame_flags_t [NUM_FRAMES-1:0] flags
);

    // R2: an access strobe leaves the flag set, whatever the scan did.
    p_ref_sets_r2: assert property (@(posedge clk) disable iff (rst)
        ref_valid |=> flags[$past(ref_index)].referenced);

    p_wr_sets_r2: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> flags[$past(wr_index)].dirty);

    // R5: accepted request starts a search.
    p_start_scan_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid) |=> busy);

    // R5: a victim comes only out of a search and lasts one cycle.
    p_victim_from_scan_r5: assert property (@(posedge clk) disable iff (rst)
        victim_valid |-> $past(busy));

    p_victim_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        victim_valid |=> !victim_valid);

    // R10: victim no longer marked modified unless written as it was chosen.
    p_victim_clean_r10: assert property (@(posedge clk) disable iff (rst)
        (victim_valid && !$past(wr_valid && wr_index == victim_index))
            |-> !flags[victim_index].dirty);

endmodule

bind nru_victim_sel nru_victim_sel_chk #(
    .NUM_FRAMES(NUM_FRAMES),
    .IDX_W     (IDX_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_valid   (ref_valid),
    .ref_index   (ref_index),
    .wr_valid    (wr_valid),
    .wr_index    (wr_index),
    .req_valid   (req_valid),
    .busy        (busy),
    .victim_valid(victim_valid),
    .victim_index(victim_index),
    .flags       (flags)
);

// File: tb/nru_victim_sel_bench.sv
module nru_victim_sel_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NF         = 8;
    localparam int NVEC       = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_valid = 1'b0;
    logic [2:0] ref_index = '0;
    logic       wr_valid = 1'b0;
    logic [2:0] wr_index = '0;
    logic       req_valid = 1'b0;
    logic       clean_mode = 1'b0;
    logic       busy;
    logic       victim_valid;
    logic [2:0] victim_index;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nru_victim_sel #(.NUM_FRAMES(NF)) u_nru_victim_sel (
        .clk         (clk),
        .rst         (rst),
        .ref_valid   (ref_valid),
        .ref_index   (ref_index),
        .wr_valid    (wr_valid),
        .wr_index    (wr_index),
        .req_valid   (req_valid),
        .clean_mode  (clean_mode),
        .busy        (busy),
        .victim_valid(victim_valid),
        .victim_index(victim_index)
    );

    // {used mask, modified mask, mode, expected index, expected examinations}
    localparam logic [24:0] VECS [NVEC] = '{
        {8'h00, 8'h00, 1'b0, 3'd0, 5'd1},   // R1 R3: nothing used
        {8'h07, 8'h00, 1'b0, 3'd3, 5'd4},   // R2 R3: skip three used frames
        {8'hFF, 8'h00, 1'b0, 3'd0, 5'd9},   // R4: all used, wrap to start
        {8'h7F, 8'h00, 1'b0, 3'd7, 5'd8},   // R3: last frame only unused
        {8'h01, 8'h06, 1'b1, 3'd3, 5'd4},   // R7: skip used and modified
        {8'h00, 8'hFF, 1'b1, 3'd0, 5'd16},  // R8: all modified, fallback
        {8'hF0, 8'h0F, 1'b1, 3'd4, 5'd13},  // R7: clean found in second sweep
        {8'h00, 8'h00, 1'b1, 3'd0, 5'd1},   // R7: first frame clean
        {8'hFF, 8'hFF, 1'b1, 3'd0, 5'd16},  // R8: fallback after clearing
        {8'hFE, 8'hFF, 1'b0, 3'd0, 5'd1}    // R3: modified ignored in plain mode
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        rst = 1'b1;
        ref_valid = 1'b0;
        wr_valid = 1'b0;
        req_valid = 1'b0;
        clean_mode = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load_masks(input logic [7:0] rm, input logic [7:0] dm);
        for (int i = 0; i < NF; i++) begin
            @(negedge clk);
            ref_valid = rm[i];
            ref_index = 3'(i);
            wr_valid  = dm[i];
            wr_index  = 3'(i);
        end
        @(negedge clk);
        ref_valid = 1'b0;
        wr_valid  = 1'b0;
    endtask

    // Issue a request; optional injections land in the first examined cycle.
    task automatic run_req(input logic mode, input bit inj_ref, input bit inj_wr,
                           input logic [2:0] inj_idx, input bit hold_alt,
                           output int idx, output int lat);
        @(negedge clk);
        req_valid  = 1'b1;
        clean_mode = mode;
        @(negedge clk);
        check(busy == 1'b1, "R5 busy after request", int'(busy), 1);
        req_valid  = hold_alt;
        clean_mode = hold_alt ? !mode : mode;
        ref_valid  = inj_ref;
        ref_index  = inj_idx;
        wr_valid   = inj_wr;
        wr_index   = inj_idx;
        @(negedge clk);
        lat = 1;
        req_valid = 1'b0;
        ref_valid = 1'b0;
        wr_valid  = 1'b0;
        while (!victim_valid && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        idx = int'(victim_index);
        @(negedge clk);
        check(victim_valid == 1'b0 && busy == 1'b0, "R5 single pulse then idle",
              int'({victim_valid, busy}), 0);
    endtask

    task automatic expect_victim(input string req, input int idx, input int lat,
                                 input int e_idx, input int e_lat);
        check(idx == e_idx, req, idx, e_idx);
        check(lat == e_lat, req, lat, e_lat);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int idx;
        int lat;
        logic [24:0] v;

        // R1: reset state at the ports
        apply_reset();
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        check(victim_valid == 1'b0, "R1 victim_valid after reset", int'(victim_valid), 0);

        // Table walk: each vector from reset
        for (int k = 0; k < NVEC; k++) begin
            v = VECS[k];
            apply_reset();
            load_masks(v[24:17], v[16:9]);
            run_req(v[8], 1'b0, 1'b0, 3'd0, 1'b0, idx, lat);
            expect_victim($sformatf("R3/R4/R7/R8 vector %0d", k), idx, lat,
                          int'(v[7:5]), int'(v[4:0]));
        end

        // R6: pointer resumes after the victim
        apply_reset();
        run_req(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, idx, lat);
        expect_victim("R6 first", idx, lat, 0, 1);
        run_req(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, idx, lat);
        expect_victim("R6 second", idx, lat, 1, 1);
        load_masks(8'h0C, 8'h00);
        run_req(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, idx, lat);
        expect_victim("R6 third from frame 2", idx, lat, 4, 3);

        // R5: a clean-mode request during a plain search is ignored
        apply_reset();
        load_masks(8'h01, 8'h02);
        run_req(1'b0, 1'b0, 1'b0, 3'd0, 1'b1, idx, lat);
        expect_victim("R5 request while busy", idx, lat, 1, 2);

        // R9: same-cycle reference on a used frame keeps its flag
        apply_reset();
        load_masks(8'hFD, 8'h00);
        run_req(1'b0, 1'b1, 1'b0, 3'd0, 1'b0, idx, lat);
        expect_victim("R9 collision search", idx, lat, 1, 2);
        run_req(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, idx, lat);
        expect_victim("R9 flag kept for next sweep", idx, lat, 1, 8);

        // R9: same-cycle reference on an unused frame prevents its choice
        apply_reset();
        run_req(1'b0, 1'b1, 1'b0, 3'd0, 1'b0, idx, lat);
        expect_victim("R9 reference wins", idx, lat, 1, 2);

        // R9: same-cycle write in clean mode makes the frame modified
        apply_reset();
        run_req(1'b1, 1'b0, 1'b1, 3'd0, 1'b0, idx, lat);
        expect_victim("R9 write wins", idx, lat, 1, 2);

        // R10: fallback victim loses its modified flag
        apply_reset();
        load_masks(8'h00, 8'hFF);
        run_req(1'b1, 1'b0, 1'b0, 3'd0, 1'b0, idx, lat);
        expect_victim("R8 fallback", idx, lat, 0, 16);
        load_masks(8'hFE, 8'h00);
        run_req(1'b1, 1'b0, 1'b0, 3'd0, 1'b0, idx, lat);
        expect_victim("R10 victim now clean", idx, lat, 0, 8);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule